// File: doc/BRIEF.md
# Delayed Transaction Timeout Error Reporter

This block watches the two kinds of delayed transaction that a bridge holds on behalf of an initiator: a posted-by-retry write that has to be delivered to a target, and a read that has to bring data back from a target. For each kind it counts the retry attempts made without progress. When a transaction uses up its attempt budget of 2^CNT_W attempts (2^24 by default), the block treats the transaction as discarded and raises an error cause for it.

Each of the two causes can be suppressed by its own mask input. Both causes are also gated by the global system-error enable taken from the command register. The surviving causes are merged into a single registered system-error request. This request is a one-clock pulse per event, and it is meant to drive the pin driver that sits outside this block.

Each transaction kind has its own tracker, a small state machine. Its states are named as follows. TRK_IDLE means nothing is pending. TRK_ACTIVE means a transaction is pending and retries are being counted. TRK_DISCARD means the budget ran out and the transaction was dropped. Its transitions are named as follows. A load moves the tracker from any state to TRK_ACTIVE and clears the count (load). In TRK_ACTIVE, a progress pulse clears the count (progress). On the write tracker, that same pulse also ends the transaction and moves it to TRK_IDLE (complete). The attempt that reaches the budget moves TRK_ACTIVE to TRK_DISCARD and fires the cause (expire). TRK_IDLE and TRK_DISCARD stay where they are until the next load.

Top module: `dtt_serr_reporter`

## Requirements
- R1: After reset, serr_req is 0 and both trackers are in TRK_IDLE, so retry pulses given before any load never produce a request.
- R2: If a loaded write gets 2^CNT_W retry pulses with no completion pulse, a write cause fires on the last of those pulses. serr_req is 1 in the clock cycle after that pulse is sampled, and it is not raised on any earlier pulse.
- R3: If a loaded read gets 2^CNT_W retry pulses with no data pulse, a read cause fires on the last pulse, with the same timing as R2.
- R4: A write completion pulse clears the write count and returns the write tracker to TRK_IDLE. Retries that follow it produce no request until the next write load.
- R5: A read data pulse clears the read count while the read stays pending. It then takes a full 2^CNT_W further retries to fire the read cause.
- R6: The mask inputs use 1 to suppress and 0 to report. wr_mask=1 suppresses only the write cause, and rd_mask=1 suppresses only the read cause. Masks are sampled in the same cycle as the expiring retry.
- R7: When serr_en is 0 in the cycle of the expiring retry, neither cause produces a request.
- R8: Each event gives exactly one request cycle. After it fires, that tracker is in TRK_DISCARD and ignores retries until a load.
- R9: A load restarts the count from zero in any state, and it takes priority over a retry in the same cycle.
- R10: A progress pulse (write completion or read data) takes priority over a retry in the same cycle.
- R11: Write and read events in the same cycle produce one request cycle. One unmasked event is enough to produce it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| serr_en | input | 1 | Global system-error enable from the command register |
| wr_mask | input | 1 | 1 = suppress write-nondelivery cause |
| rd_mask | input | 1 | 1 = suppress read-no-data cause |
| wr_load | input | 1 | New delayed write accepted; restart its count |
| wr_retry | input | 1 | One retry attempt of the pending write |
| wr_done | input | 1 | Pending write delivered |
| rd_load | input | 1 | New delayed read accepted; restart its count |
| rd_retry | input | 1 | One retry attempt of the pending read |
| rd_data | input | 1 | One data word returned for the pending read |
| serr_req | output | 1 | Registered one-cycle system-error request |

## Verification
The bench aims at the edge of the budget. It checks that the request comes on attempt 2^CNT_W and not one attempt earlier or later, so an off-by-one counter shows up as a missing or shifted pulse. It checks same-cycle collisions in which load or progress meets a retry. A design with the wrong priority would fire early or would fail to restart. Retries after an expiry and after a write completion are also driven, so a tracker that does not stop would give repeated pulses. Masks, the global enable and simultaneous events are crossed with each other, so that swapped masks or a missing enable gate show up as a request that is wrong or missing.

// File: rtl/dtt_pkg.sv
package dtt_pkg;
    typedef enum logic [1:0] {
        TRK_IDLE    = 2'd0,
        TRK_ACTIVE  = 2'd1,
        TRK_DISCARD = 2'd2
    } trk_state_e;

    localparam int unsigned NUM_CAUSES = 2;
    localparam int unsigned CAUSE_WR   = 0;
    localparam int unsigned CAUSE_RD   = 1;
endpackage

// File: rtl/dtt_tracker.sv
module dtt_tracker
    import dtt_pkg::*;
#(
    parameter int unsigned CNT_W           = 24,
    parameter bit          END_ON_PROGRESS = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  logic retry_i,
    input  logic progress_i,
    output logic expire_o
);
    localparam logic [CNT_W-1:0] CNT_LAST = {CNT_W{1'b1}};

    trk_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             last_attempt;

    assign last_attempt = retry_i && (cnt_q == CNT_LAST);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TRK_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (load_i) begin
            state_d = TRK_ACTIVE;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                TRK_IDLE: begin
                    cnt_d = '0;
                end
                TRK_ACTIVE: begin
                    if (progress_i) begin
                        cnt_d = '0;
                        if (END_ON_PROGRESS) state_d = TRK_IDLE;
                    end else if (last_attempt) begin
                        cnt_d   = '0;
                        state_d = TRK_DISCARD;
                    end else if (retry_i) begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                TRK_DISCARD: begin
                    cnt_d = '0;
                end
                default: begin
                    state_d = TRK_IDLE;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    always_comb begin
        expire_o = 1'b0;
        unique case (state_q)
            TRK_ACTIVE: expire_o = !load_i && !progress_i && last_attempt;
            default:    expire_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/dtt_cause_gate.sv
module dtt_cause_gate #(
    parameter int unsigned N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] cause_i,
    input  logic [N-1:0] mask_i,
    input  logic         enable_i,
    output logic         req_o
);
    logic [N-1:0] live;

    assign live = cause_i & ~mask_i;

    always_ff @(posedge clk) begin
        if (!rst_n) req_o <= 1'b0;
        else        req_o <= enable_i && (|live);
    end
endmodule

// File: rtl/dtt_serr_reporter.sv
module dtt_serr_reporter
    import dtt_pkg::*;
#(
    parameter int unsigned CNT_W = 24
) (
    input  logic clk,
    input  logic rst_n,
    input  logic serr_en,
    input  logic wr_mask,
    input  logic rd_mask,
    input  logic wr_load,
    input  logic wr_retry,
    input  logic wr_done,
    input  logic rd_load,
    input  logic rd_retry,
    input  logic rd_data,
    output logic serr_req
);
    logic [NUM_CAUSES-1:0] load_v, retry_v, prog_v, mask_v, cause_v;

    assign load_v[CAUSE_WR]  = wr_load;
    assign load_v[CAUSE_RD]  = rd_load;
    assign retry_v[CAUSE_WR] = wr_retry;
    assign retry_v[CAUSE_RD] = rd_retry;
    assign prog_v[CAUSE_WR]  = wr_done;
    assign prog_v[CAUSE_RD]  = rd_data;
    assign mask_v[CAUSE_WR]  = wr_mask;
    assign mask_v[CAUSE_RD]  = rd_mask;

    for (genvar c = 0; c < NUM_CAUSES; c++) begin : g_trk
        dtt_tracker #(
            .CNT_W          (CNT_W),
            .END_ON_PROGRESS(c == CAUSE_WR)
        ) trk_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .load_i    (load_v[c]),
            .retry_i   (retry_v[c]),
            .progress_i(prog_v[c]),
            .expire_o  (cause_v[c])
        );
    end

    dtt_cause_gate #(
        .N(NUM_CAUSES)
    ) gate_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .cause_i (cause_v),
        .mask_i  (mask_v),
        .enable_i(serr_en),
        .req_o   (serr_req)
    );
endmodule

// File: rtl/dtt_serr_reporter_chk.sv
module dtt_serr_reporter_chk (
    input logic clk,
    input logic rst_n,
    input logic serr_en,
    input logic wr_mask,
    input logic rd_mask,
    input logic wr_load,
    input logic wr_retry,
    input logic rd_load,
    input logic rd_retry,
    input logic serr_req
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> !serr_req);

    // R7
    enable_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        serr_req |-> $past(serr_en));

    // R6
    mask_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        serr_req |-> !($past(wr_mask) && $past(rd_mask)));

    // R2
    retry_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        serr_req |-> $past(wr_retry || rd_retry));

    // R9
    load_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
        serr_req |-> !($past(wr_load) && $past(rd_load)));
endmodule

bind dtt_serr_reporter dtt_serr_reporter_chk chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .serr_en (serr_en),
    .wr_mask (wr_mask),
    .rd_mask (rd_mask),
    .wr_load (wr_load),
    .wr_retry(wr_retry),
    .rd_load (rd_load),
    .rd_retry(rd_retry),
    .serr_req(serr_req)
);

// File: tb/dtt_serr_reporter_tb_top.sv
module dtt_serr_reporter_tb_top;
    localparam int unsigned CW     = 4;
    localparam int unsigned BUDGET = 1 << CW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic serr_en = 1'b0, wr_mask = 1'b0, rd_mask = 1'b0;
    logic wr_load = 1'b0, wr_retry = 1'b0, wr_done = 1'b0;
    logic rd_load = 1'b0, rd_retry = 1'b0, rd_data = 1'b0;
    logic serr_req;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // model: 0 idle, 1 pending, 2 dropped
    int m_st[2];
    int m_cnt[2];

    always #2.5 clk = ~clk;

    dtt_serr_reporter #(.CNT_W(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .serr_en(serr_en),
        .wr_mask(wr_mask), .rd_mask(rd_mask),
        .wr_load(wr_load), .wr_retry(wr_retry), .wr_done(wr_done),
        .rd_load(rd_load), .rd_retry(rd_retry), .rd_data(rd_data),
        .serr_req(serr_req)
    );

    function automatic bit model_hit(int ch, bit ld, bit rt, bit pg);
        return !ld && !pg && rt && m_st[ch] == 1 && m_cnt[ch] == BUDGET - 1;
    endfunction

    task automatic model_adv(int ch, bit ld, bit rt, bit pg, bit ends);
        if (ld) begin
            m_st[ch] = 1; m_cnt[ch] = 0;
        end else if (m_st[ch] == 1) begin
            if (pg) begin
                m_cnt[ch] = 0;
                if (ends) m_st[ch] = 0;
            end else if (rt) begin
                if (m_cnt[ch] == BUDGET - 1) begin
                    m_st[ch] = 2; m_cnt[ch] = 0;
                end else m_cnt[ch]++;
            end
        end
    endtask

    task automatic check(string tag, bit act, bit exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: serr_req=%0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    // apply current inputs for one clock and check the request after it
    task automatic step(string tag);
        bit hw, hr, exp;
        hw = model_hit(0, wr_load, wr_retry, wr_done);
        hr = model_hit(1, rd_load, rd_retry, rd_data);
        exp = serr_en && ((hw && !wr_mask) || (hr && !rd_mask));
        model_adv(0, wr_load, wr_retry, wr_done, 1'b1);
        model_adv(1, rd_load, rd_retry, rd_data, 1'b0);
        @(posedge clk);
        @(negedge clk);
        check(tag, serr_req, exp);
    endtask

    task automatic idle_in();
        wr_load = 0; wr_retry = 0; wr_done = 0;
        rd_load = 0; rd_retry = 0; rd_data = 0;
    endtask

    task automatic wr_retries(int n, string tag);
        for (int i = 0; i < n; i++) begin
            idle_in(); wr_retry = 1; step(tag);
        end
        idle_in();
    endtask

    task automatic rd_retries(int n, string tag);
        for (int i = 0; i < n; i++) begin
            idle_in(); rd_retry = 1; step(tag);
        end
        idle_in();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240607));
        m_st = '{0, 0}; m_cnt = '{0, 0};
        repeat (3) @(negedge clk);
        check("R1 reset", serr_req, 1'b0);
        rst_n = 1;
        serr_en = 1;

        // R1: retries before any load do nothing
        wr_retries(BUDGET + 2, "R1 no-load write");
        rd_retries(BUDGET + 2, "R1 no-load read");

        // R2 / R8: write expires on exactly the budget-th retry, then ignored
        idle_in(); wr_load = 1; step("R9 write load");
        wr_retries(BUDGET - 1, "R2 write before budget");
        wr_retry = 1; step("R2 write expiry");
        wr_retries(BUDGET + 3, "R8 write discarded");

        // R3: read expiry
        idle_in(); rd_load = 1; step("R9 read load");
        rd_retries(BUDGET, "R3 read expiry");

        // R5: data word restarts the read budget
        idle_in(); rd_load = 1; step("R9 read load");
        rd_retries(10, "R5 read partial");
        idle_in(); rd_data = 1; step("R5 data word");
        rd_retries(BUDGET - 1, "R5 after data");
        rd_retry = 1; step("R5 read late expiry");

        // R4: write completion ends the transaction
        idle_in(); wr_load = 1; step("R4 load");
        wr_retries(7, "R4 partial");
        idle_in(); wr_done = 1; step("R4 done");
        wr_retries(BUDGET + 2, "R4 after done");

        // R10: progress beats retry in the same cycle
        idle_in(); rd_load = 1; step("R10 load");
        rd_retries(BUDGET - 1, "R10 partial");
        idle_in(); rd_retry = 1; rd_data = 1; step("R10 data+retry");
        rd_retries(BUDGET, "R10 full budget again");

        // R9: load beats retry at the last attempt
        idle_in(); wr_load = 1; step("R9 load");
        wr_retries(BUDGET - 1, "R9 partial");
        idle_in(); wr_retry = 1; wr_load = 1; step("R9 load+retry");
        wr_retries(BUDGET, "R9 restarted budget");

        // R6: each mask suppresses only its own cause
        wr_mask = 1;
        idle_in(); wr_load = 1; rd_load = 1; step("R6 loads");
        wr_retries(BUDGET, "R6 write masked");
        rd_retries(BUDGET, "R6 read unmasked");
        wr_mask = 0; rd_mask = 1;
        idle_in(); wr_load = 1; rd_load = 1; step("R6 loads");
        rd_retries(BUDGET, "R6 read masked");
        wr_retries(BUDGET, "R6 write unmasked");
        rd_mask = 0;

        // R7: global enable off
        serr_en = 0;
        idle_in(); wr_load = 1; rd_load = 1; step("R7 loads");
        for (int i = 0; i < BUDGET; i++) begin
            idle_in(); wr_retry = 1; rd_retry = 1; step("R7 enable off");
        end
        serr_en = 1;

        // R11: simultaneous expiry, and one-sided mask
        idle_in(); wr_load = 1; rd_load = 1; step("R11 loads");
        for (int i = 0; i < BUDGET; i++) begin
            idle_in(); wr_retry = 1; rd_retry = 1; step("R11 both expire");
        end
        idle_in(); step("R11 single pulse");
        wr_mask = 1;
        idle_in(); wr_load = 1; rd_load = 1; step("R11 loads");
        for (int i = 0; i < BUDGET; i++) begin
            idle_in(); wr_retry = 1; rd_retry = 1; step("R11 one unmasked");
        end
        wr_mask = 0;

        // random traffic against the model
        for (int i = 0; i < 4000; i++) begin
            wr_load  = ($urandom % 64) == 0;
            rd_load  = ($urandom % 64) == 0;
            wr_retry = ($urandom % 4) != 0;
            rd_retry = ($urandom % 4) != 0;
            wr_done  = ($urandom % 48) == 0;
            rd_data  = ($urandom % 40) == 0;
            if (($urandom % 100) == 0) wr_mask = $urandom;
            if (($urandom % 100) == 0) rd_mask = $urandom;
            if (($urandom % 150) == 0) serr_en = $urandom;
            step("R2/R3/R6/R7 random");
        end

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule